// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block is the receive-side descriptor engine of an Ethernet MAC. Software builds a ring of descriptors in a descriptor memory. Each descriptor is one 64-bit word holding a status halfword, a length and a buffer address. Software marks a descriptor as handed to the engine by setting its empty bit, and the last descriptor of the ring carries a wrap bit. The engine fetches the current descriptor. When a frame arrives on the byte-stream MAC input, the engine stores the frame bytes into that descriptor's buffer. It then writes the descriptor back with the empty bit clear, the byte count and the error flags. After that it moves to the next descriptor, or back to the ring base after a wrap descriptor.

If the engine finds a descriptor that software has not yet returned, it stops polling. Frames that start while no empty descriptor is in hand are dropped and counted. Software resumes the engine by writing the kick register once it has refilled the ring. Each completed frame gives a one-cycle event and sets a sticky flag, which software clears by writing a one to it. CRC checking is done upstream, so a bad CRC arrives as an input flag with the last byte.

Descriptor word layout: bits 63:48 status, bits 47:32 length, bits 31:0 buffer byte address. Status bits: 15 = empty (owned by the engine), 13 = wrap, 1 = frame too long, 0 = CRC bad. Register select values: 0 = ring base index, 1 = control (bit 0 enable), 2 = kick, 3 = event clear.

Top module: `rxd_ring_mgr`

## Requirements
- R1: After reset no descriptor read or write is issued, frame_sticky is 0 and missed_cnt is 0.
- R2: When enable (control register, reg_sel 1, bit 0) goes to 1, the first descriptor read is at the index held in the ring base register (reg_sel 0). A descriptor read and a descriptor write never happen in the same cycle.
- R3: A frame that starts while an empty descriptor is in hand has its bytes written in arrival order to buffer address + 0, + 1, and so on, one write per input byte.
- R4: At the end of a frame the descriptor is written back with status bit 15 (empty) at 0, bit 13 (wrap) as fetched, the length field equal to the number of bytes stored (the 4-byte FCS included), and the buffer address unchanged.
- R5: After writing back a descriptor with the wrap bit set, the next descriptor read is at the ring base index. Otherwise it is at the index plus one.
- R6: Status bit 0 is set when rx_crc_bad is high with the last byte. A good frame of normal length has status bits 5:0 all zero, and a frame of a single byte is handled like any other.
- R7: A frame longer than MAX_LEN (1518) bytes stores only the first MAX_LEN bytes. It is written back with length MAX_LEN and status bit 1 set.
- R8: If the fetched descriptor has its empty bit clear, the engine stops polling. Every frame that starts while enabled and without an empty descriptor in hand is dropped, with no buffer writes, and missed_cnt rises by one. Setting the empty bit in memory does not resume the engine. A kick (reg_sel 2 with bit 24 set) re-reads the same descriptor.
- R9: A write to the kick register with bit 24 clear has no effect, and the engine stays stopped.
- R10: Each written-back frame gives frame_evt high for exactly one cycle and sets frame_sticky. Writing reg_sel 3 with bit 0 set clears it, and writing bit 0 clear leaves it set.
- R11: While enable is 0, frames cause no buffer writes and do not change missed_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | MAC byte valid |
| rx_data | input | 8 | MAC byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_crc_bad | input | 1 | CRC error flag, sampled with the last byte |
| desc_rd | output | 1 | Descriptor read request (data returns one cycle later) |
| desc_wr | output | 1 | Descriptor write-back strobe |
| desc_addr | output | AW | Descriptor index |
| desc_wdata | output | 64 | Descriptor write-back word |
| desc_rdata | input | 64 | Descriptor read word |
| buf_wr | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte |
| frame_evt | output | 1 | One-cycle frame-completed event |
| frame_sticky | output | 1 | Sticky frame-received flag |
| missed_cnt | output | CW | Count of dropped frames |

## Verification
The hardest state to reach is the stalled engine. Getting there means wrapping all the way around the ring, back to a descriptor that software has not returned. Once there, the bench must show that the engine stays stopped even after the memory is repaired, until a correctly formed kick arrives. The stimulus fills every descriptor of a three-entry ring. The last of these frames is oversized and lands on the wrap entry. Frames are then sent against the stale head descriptor, before and after software marks it empty, and after a kick written with the wrong bit. Only a proper kick then lets a frame land, and the bench checks that the following read moves on to the next index.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // status halfword bit positions (software decodes these)
  localparam int STAT_EMPTY    = 15;
  localparam int STAT_WRAP     = 13;
  localparam int STAT_ERR_LONG = 1;
  localparam int STAT_ERR_CRC  = 0;
  localparam int KICK_BIT      = 24;

  localparam logic [1:0] REG_BASE  = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_KICK  = 2'd2;
  localparam logic [1:0] REG_EVCLR = 2'd3;

  typedef struct packed {
    logic [15:0] stat;
    logic [15:0] len;
    logic [31:0] buf_addr;
  } rx_desc_t;

  typedef enum logic [2:0] {
    ST_OFF, ST_FETCH, ST_WAIT, ST_READY, ST_RECV, ST_WB, ST_STALL
  } ring_state_e;

  function automatic logic [15:0] done_status(input logic wrap, input logic crc_bad,
                                              input logic too_long);
    logic [15:0] s;
    s = '0;
    s[STAT_WRAP]     = wrap;
    s[STAT_ERR_CRC]  = crc_bad;
    s[STAT_ERR_LONG] = too_long;
    return s;
  endfunction
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          frame_done,
  output logic [AW-1:0] ring_base,
  output logic          eng_en,
  output logic          kick,
  output logic          frame_sticky
);
  logic clr_evt;
  logic unused_wdata;

  assign kick         = reg_wr && (reg_sel == REG_KICK) && reg_wdata[KICK_BIT];
  assign clr_evt      = reg_wr && (reg_sel == REG_EVCLR) && reg_wdata[0];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_base    <= '0;
      eng_en       <= 1'b0;
      frame_sticky <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == REG_BASE) ring_base <= reg_wdata[AW-1:0];
      if (reg_wr && reg_sel == REG_CTRL) eng_en <= reg_wdata[0];
      if (frame_done)   frame_sticky <= 1'b1;
      else if (clr_evt) frame_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/rxd_fill.sv
module rxd_fill #(
  parameter int LW      = 16,
  parameter int MAX_LEN = 1518
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_recv,
  input  logic          rx_valid,
  input  logic          rx_last,
  input  logic          rx_crc_bad,
  input  logic [7:0]    rx_data,
  input  logic [31:0]   buf_base,
  output logic          buf_wr,
  output logic [31:0]   buf_addr,
  output logic [7:0]    buf_data,
  output logic          done,
  output logic [LW-1:0] len_q,
  output logic          crc_q,
  output logic          long_q
);
  logic          take;
  logic          room;
  logic [LW-1:0] cnt_cur;

  function automatic logic fits(input logic [LW-1:0] n);
    return n < LW'(MAX_LEN);
  endfunction

  assign take     = start | (in_recv & rx_valid);
  assign cnt_cur  = start ? '0 : len_q;
  assign room     = fits(cnt_cur);
  assign buf_wr   = take & room;
  assign buf_addr = buf_base + 32'(cnt_cur);
  assign buf_data = rx_data;
  assign done     = take & rx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      crc_q  <= 1'b0;
      long_q <= 1'b0;
    end else if (take) begin
      len_q  <= cnt_cur + {{(LW-1){1'b0}}, room};
      long_q <= (start ? 1'b0 : long_q) | ~room;
      if (rx_last) crc_q <= rx_crc_bad;
    end
  end
endmodule

// File: rtl/rxd_ring.sv
module rxd_ring
  import rxd_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_en,
  input  logic          kick,
  input  logic [AW-1:0] ring_base,
  input  logic          sof,
  input  logic [63:0]   desc_rdata,
  input  logic          fill_done,
  input  logic [LW-1:0] len_q,
  input  logic          crc_q,
  input  logic          long_q,
  output logic          desc_rd,
  output logic          desc_wr,
  output logic [AW-1:0] desc_addr,
  output logic [63:0]   desc_wdata,
  output logic          in_recv,
  output logic          accept,
  output logic          drop,
  output logic          frame_done,
  output logic [31:0]   cur_buf,
  output logic [CW-1:0] missed_cnt
);
  ring_state_e   state;
  logic [AW-1:0] idx;
  logic          cur_wrap;
  rx_desc_t      rdesc;
  logic          unused_rd;

  function automatic logic [AW-1:0] next_index(input logic [AW-1:0] cur, input logic wrap,
                                               input logic [AW-1:0] base);
    return wrap ? base : cur + AW'(1);
  endfunction

  assign rdesc      = rx_desc_t'(desc_rdata);
  assign unused_rd  = ^{rdesc.len, rdesc.stat[14], rdesc.stat[12:0]};
  assign desc_rd    = (state == ST_FETCH);
  assign desc_wr    = (state == ST_WB);
  assign frame_done = desc_wr;
  assign desc_addr  = idx;
  assign desc_wdata = {done_status(cur_wrap, crc_q, long_q), 16'(len_q), cur_buf};
  assign in_recv    = (state == ST_RECV);
  assign accept     = sof & eng_en & (state == ST_READY);
  assign drop       = sof & eng_en & (state != ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      idx        <= '0;
      cur_buf    <= '0;
      cur_wrap   <= 1'b0;
      missed_cnt <= '0;
    end else begin
      if (drop) missed_cnt <= missed_cnt + CW'(1);
      if (!eng_en) begin
        state <= ST_OFF;
      end else begin
        case (state)
          ST_OFF: begin
            idx   <= ring_base;
            state <= ST_FETCH;
          end
          ST_FETCH: state <= ST_WAIT;
          ST_WAIT: begin
            if (rdesc.stat[STAT_EMPTY]) begin
              cur_buf  <= rdesc.buf_addr;
              cur_wrap <= rdesc.stat[STAT_WRAP];
              state    <= ST_READY;
            end else begin
              state <= ST_STALL;
            end
          end
          ST_READY: if (accept) state <= fill_done ? ST_WB : ST_RECV;
          ST_RECV:  if (fill_done) state <= ST_WB;
          ST_WB: begin
            idx   <= next_index(idx, cur_wrap, ring_base);
            state <= ST_FETCH;
          end
          ST_STALL: if (kick) state <= ST_FETCH;
          default:  state <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxd_ring_mgr.sv
module rxd_ring_mgr #(
  parameter int AW      = 4,
  parameter int CW      = 16,
  parameter int MAX_LEN = 1518
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_bad,
  output logic          desc_rd,
  output logic          desc_wr,
  output logic [AW-1:0] desc_addr,
  output logic [63:0]   desc_wdata,
  input  logic [63:0]   desc_rdata,
  output logic          buf_wr,
  output logic [31:0]   buf_addr,
  output logic [7:0]    buf_data,
  output logic          frame_evt,
  output logic          frame_sticky,
  output logic [CW-1:0] missed_cnt
);
  localparam int LW = 16;

  logic          in_frame;
  logic          sof;
  logic          eng_en;
  logic          kick;
  logic [AW-1:0] ring_base;
  logic          in_recv;
  logic          accept;
  logic          drop;
  logic          fill_done;
  logic [LW-1:0] len_q;
  logic          crc_q;
  logic          long_q;
  logic [31:0]   cur_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_frame <= 1'b0;
    else if (rx_valid) in_frame <= ~rx_last;
  end
  assign sof = rx_valid & ~in_frame;

  rxd_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_done(frame_evt), .ring_base(ring_base), .eng_en(eng_en), .kick(kick),
    .frame_sticky(frame_sticky)
  );

  rxd_ring #(.AW(AW), .CW(CW), .LW(LW)) ring_i (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .kick(kick), .ring_base(ring_base),
    .sof(sof), .desc_rdata(desc_rdata), .fill_done(fill_done), .len_q(len_q),
    .crc_q(crc_q), .long_q(long_q), .desc_rd(desc_rd), .desc_wr(desc_wr),
    .desc_addr(desc_addr), .desc_wdata(desc_wdata), .in_recv(in_recv), .accept(accept),
    .drop(drop), .frame_done(frame_evt), .cur_buf(cur_buf), .missed_cnt(missed_cnt)
  );

  rxd_fill #(.LW(LW), .MAX_LEN(MAX_LEN)) fill_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .in_recv(in_recv), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_crc_bad(rx_crc_bad), .rx_data(rx_data), .buf_base(cur_buf),
    .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_data(buf_data), .done(fill_done),
    .len_q(len_q), .crc_q(crc_q), .long_q(long_q)
  );
endmodule

// File: rtl/rxd_ring_mgr_chk.sv
module rxd_ring_mgr_chk #(
  parameter int AW      = 4,
  parameter int CW      = 16,
  parameter int MAX_LEN = 1518
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_en,
  input logic          drop,
  input logic          desc_rd,
  input logic          desc_wr,
  input logic [63:0]   desc_wdata,
  input logic          buf_wr,
  input logic          frame_evt,
  input logic          frame_sticky,
  input logic [CW-1:0] missed_cnt
);
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_rd && desc_wr));
  assert_wb_empty_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |-> !desc_wdata[63]);
  assert_fetch_after_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr && eng_en) |=> desc_rd);
  assert_len_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |-> (desc_wdata[47:32] <= 16'(MAX_LEN)));
  assert_drop_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (missed_cnt == $past(missed_cnt) + CW'(1)));
  assert_evt_is_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |-> desc_wr);
  assert_evt_sets_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> frame_sticky);
  assert_off_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |=> !buf_wr);
endmodule

bind rxd_ring_mgr rxd_ring_mgr_chk #(.AW(AW), .CW(CW), .MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .drop(drop), .desc_rd(desc_rd),
  .desc_wr(desc_wr), .desc_wdata(desc_wdata), .buf_wr(buf_wr), .frame_evt(frame_evt),
  .frame_sticky(frame_sticky), .missed_cnt(missed_cnt)
);

// File: tb/rxd_ring_mgr_tb_top.sv
`timescale 1ns/100ps
module rxd_ring_mgr_tb_top;
  localparam int AW = 4;
  localparam int CW = 16;
  localparam int MAXL = 1518;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_bad = 1'b0;
  logic [7:0] rx_data = '0;
  logic desc_rd, desc_wr, buf_wr, frame_evt, frame_sticky;
  logic [AW-1:0] desc_addr;
  logic [63:0] desc_wdata;
  logic [63:0] desc_rdata = '0;
  logic [31:0] buf_addr;
  logic [7:0] buf_data;
  logic [CW-1:0] missed_cnt;

  always #2.5 clk = ~clk;

  rxd_ring_mgr #(.AW(AW), .CW(CW), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_bad(rx_crc_bad),
    .desc_rd(desc_rd), .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
    .desc_rdata(desc_rdata), .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_data(buf_data),
    .frame_evt(frame_evt), .frame_sticky(frame_sticky), .missed_cnt(missed_cnt)
  );

  // behavioural memories
  logic [63:0] mem [16];
  logic [7:0]  bufm [int];
  int nbw = 0, evts = 0, cyc = 0, checks = 0, errors = 0;
  int last_rd = -1;
  int exp_missed = 0;

  always @(posedge clk) begin
    cyc++;
    if (desc_rd) begin
      desc_rdata <= mem[desc_addr];
      last_rd    <= int'(desc_addr);
    end
    if (desc_wr) mem[desc_addr] = desc_wdata;
    if (buf_wr) begin
      bufm[int'(buf_addr)] = buf_data;
      nbw++;
    end
    if (frame_evt) evts++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit crcb, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(seed + i * 7);
      rx_last = (i == n - 1); rx_crc_bad = crcb && (i == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_bad = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [63:0] mk_desc(input bit empty, input bit wrap, input int len,
                                          input int addr);
    logic [15:0] st;
    st = '0;
    st[15] = empty;
    st[13] = wrap;
    return {st, 16'(len), 32'(addr)};
  endfunction

  // expected write-back computed from the requirements
  function automatic logic [63:0] exp_wb(input bit wrap, input int len, input bit crcb,
                                         input int addr);
    logic [15:0] st;
    st = '0;
    st[13] = wrap;
    st[0] = crcb;
    st[1] = (len > MAXL);
    return {st, 16'((len > MAXL) ? MAXL : len), 32'(addr)};
  endfunction

  task automatic chk_bytes(input int base, input int n, input int seed, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (!bufm.exists(base + i) || bufm[base + i] !== 8'(seed + i * 7)) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int nb;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(desc_rd == 0 && desc_wr == 0, "R1 no desc access", {desc_rd, desc_wr}, 0);
    chk(frame_sticky == 0, "R1 sticky", frame_sticky, 0);
    chk(missed_cnt == 0, "R1 missed", missed_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(desc_rd == 0, "R1 idle after reset", desc_rd, 0);

    mem[4] = mk_desc(1, 0, 0, 32'h1000);
    mem[5] = mk_desc(1, 0, 0, 32'h2000);
    mem[6] = mk_desc(1, 1, 0, 32'h3000);
    wr_reg(2'd0, 32'd4);
    wr_reg(2'd1, 32'd1);
    repeat (4) @(negedge clk);
    chk(last_rd == 4, "R2 first fetch at base", last_rd, 4);

    // R3 R4 R6 good frame
    send_frame(64, 0, 3);
    chk(mem[4] == exp_wb(0, 64, 0, 32'h1000), "R4 R6 wb good", mem[4], exp_wb(0, 64, 0, 32'h1000));
    chk_bytes(32'h1000, 64, 3, "R3 bytes frame 1");
    chk(evts == 1, "R10 one event", evts, 1);
    chk(frame_sticky == 1, "R10 sticky set", frame_sticky, 1);
    chk(last_rd == 5, "R5 next index", last_rd, 5);
    wr_reg(2'd3, 32'd0);
    chk(frame_sticky == 1, "R10 clear with 0 ignored", frame_sticky, 1);
    wr_reg(2'd3, 32'd1);
    chk(frame_sticky == 0, "R10 clear with 1", frame_sticky, 0);

    // R6 single byte with bad CRC
    send_frame(1, 1, 9);
    chk(mem[5] == exp_wb(0, 1, 1, 32'h2000), "R6 crc flag", mem[5], exp_wb(0, 1, 1, 32'h2000));
    chk_bytes(32'h2000, 1, 9, "R3 single byte");

    // R7 oversized into wrap descriptor
    send_frame(1530, 0, 5);
    chk(mem[6] == exp_wb(1, 1530, 0, 32'h3000), "R7 R4 long wb", mem[6], exp_wb(1, 1530, 0, 32'h3000));
    chk_bytes(32'h3000, MAXL, 5, "R7 stored bytes");
    chk(!bufm.exists(32'h3000 + MAXL), "R7 no byte past limit", bufm.exists(32'h3000 + MAXL), 0);
    chk(last_rd == 4, "R5 wrap to base", last_rd, 4);
    chk(evts == 3, "R10 event count", evts, 3);

    // R8 stalled on stale descriptor
    nb = nbw;
    send_frame(10, 0, 1);
    exp_missed++;
    chk(missed_cnt == CW'(exp_missed), "R8 drop counted", missed_cnt, exp_missed);
    chk(nbw == nb, "R8 no writes on drop", nbw, nb);
    mem[4] = mk_desc(1, 0, 0, 32'h1000);
    send_frame(10, 0, 1);
    exp_missed++;
    chk(missed_cnt == CW'(exp_missed), "R8 still stalled", missed_cnt, exp_missed);
    chk(nbw == nb, "R8 no writes stalled", nbw, nb);

    // R9 wrong kick
    wr_reg(2'd2, 32'h0000_0001);
    send_frame(10, 0, 1);
    exp_missed++;
    chk(missed_cnt == CW'(exp_missed), "R9 bad kick ignored", missed_cnt, exp_missed);
    chk(nbw == nb, "R9 no writes", nbw, nb);

    // R8 proper kick resumes
    wr_reg(2'd2, 32'h0100_0000);
    repeat (3) @(negedge clk);
    send_frame(20, 0, 11);
    chk(mem[4] == exp_wb(0, 20, 0, 32'h1000), "R8 resumed wb", mem[4], exp_wb(0, 20, 0, 32'h1000));
    chk_bytes(32'h1000, 20, 11, "R8 resumed bytes");
    chk(last_rd == 5, "R5 after resume", last_rd, 5);
    chk(missed_cnt == CW'(exp_missed), "R8 no extra miss", missed_cnt, exp_missed);

    // R11 disabled
    wr_reg(2'd1, 32'd0);
    nb = nbw;
    send_frame(12, 0, 2);
    chk(nbw == nb, "R11 no writes when off", nbw, nb);
    chk(missed_cnt == CW'(exp_missed), "R11 no count when off", missed_cnt, exp_missed);
    chk(evts == 4, "R10 final event count", evts, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule